// File: doc/BRIEF.md
# Mailbox Doorbell Register Block

This block is the register window of a shared-memory mailbox. A 256-byte address space on a simple 32-bit register bus holds four words: an interrupt enable mask, an interrupt status word that is cleared by the act of reading it, a read-only word that reports the identity of the local peer, and a write-only doorbell. Software rings a remote peer by writing the doorbell. The destination peer is in the upper half of the word and the vector number is in the low byte. If the pair is valid, the block raises one bit of a one-hot notify bus for exactly one cycle.

Each peer has a small table entry that holds how many vectors it has registered. A separate configuration port fills the table. A doorbell is dropped without any trace when the destination is not a known peer or when the vector is not below that peer's count. A local event input writes 1 into the status word when message-signalled delivery is off. The level interrupt output is the OR of the status bits that the mask enables.

Bus accesses are steered by a three-state controller. ST_IDLE accepts a request. A read moves it to ST_RDATA, where the captured data is presented for one cycle. A valid doorbell moves it to ST_RING, where the notify bit is driven for one cycle. Both states return to ST_IDLE on the next edge. Register writes and dropped doorbells take effect at acceptance and leave the controller in ST_IDLE.

Top module: `mbox_bell_regs`

## Requirements
- R1: After reset the mask and status words are zero, irq is low, notify is all zero, bus_ready is high and bus_rvalid is low; every table count is zero.
- R2: The mask word is at offset 0x00 and is written and read back as 32 bits. On writes, address bits 1:0 are ignored, so a write to 0x01 updates the mask.
- R3: A read of offset 0x04 returns the status word and clears it to zero at the same edge. A following read returns zero.
- R4: A write to offset 0x04 loads the status word with the write data.
- R5: A read of offset 0x08 returns local_id zero-extended to 32 bits. Writes to 0x08 change nothing.
- R6: Reads decode the full address: any offset other than 0x00, 0x04 and 0x08, including an unaligned one such as 0x02, returns zero. Writes to undefined offsets change no register.
- R7: A doorbell write to offset 0x0C takes the destination from bits 31:16 and the vector from bits 7:0, and bits 15:8 are ignored. If the pair is valid, notify bit (destination × MAX_VEC + vector) is high for exactly the cycle after acceptance, and it is the only bit set.
- R8: A doorbell whose destination is not below NUM_PEERS is dropped and no notify bit rises.
- R9: A doorbell whose vector is not below the destination's table count is dropped. The configuration port writes a peer's count, and values above MAX_VEC are stored as MAX_VEC.
- R10: With msi_mode low, a local_event cycle sets the status word to 1 at the next edge. With msi_mode high, the event has no effect on status.
- R11: When a local event coincides with a status read-clear or a status write, the status word ends at 1.
- R12: irq is high exactly when status AND mask is nonzero.
- R13: Read data appears with bus_rvalid high in the cycle after acceptance. bus_ready is low in that cycle and in the notify cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| local_id | input | 16 | Identity of the local peer |
| msi_mode | input | 1 | 1 = message-signalled delivery, local events leave status alone |
| local_event | input | 1 | Incoming event for the local peer |
| cfg_we | input | 1 | Table write strobe |
| cfg_peer | input | PEER_W | Peer whose count is written |
| cfg_count | input | CNT_W | Registered vector count |
| notify | output | NUM_PEERS*MAX_VEC | One-hot single-cycle doorbell pulse |
| irq | output | 1 | Level interrupt, OR of status AND mask |

## Verification
The hardest case to reach is a local event that lands on the same clock edge as a status read-clear or a status write, because the two updates then compete for the register. The stimulus raises local_event in the same cycle as the bus request and then reads the status word a second time to see which update won. The dropped-doorbell rules are reached by programming uneven table counts, one of them above the clamp, and then ringing vectors on each side of every count, along with destinations just past the last peer and far past it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_RING  = 2'd2
    } mbox_state_e;

    localparam logic [7:0] OFS_MASK = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_POS  = 8'h08;
    localparam logic [7:0] OFS_BELL = 8'h0C;

endpackage

// File: rtl/mbox_vec_table.sv
module mbox_vec_table #(
    parameter int NUM_PEERS = 4,
    parameter int MAX_VEC   = 4,
    parameter int PEER_W    = 2,
    parameter int CNT_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [PEER_W-1:0]          cfg_peer,
    input  logic [CNT_W-1:0]           cfg_count,
    output logic [NUM_PEERS*CNT_W-1:0] counts_flat
);
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_VEC);

    logic [CNT_W-1:0] clamped;
    assign clamped = (cfg_count > MAXC) ? MAXC : cfg_count;

    for (genvar p = 0; p < NUM_PEERS; p++) begin : g_peer
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (cfg_we && (cfg_peer == PEER_W'(p))) begin
                cnt_q <= clamped;
            end
        end

        assign counts_flat[p*CNT_W +: CNT_W] = cnt_q;

        // R9: a stored count never exceeds the vector limit
        assert_count_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= MAXC);
    end
endmodule

// File: rtl/mbox_bell_check.sv
module mbox_bell_check #(
    parameter int NUM_PEERS = 4,
    parameter int MAX_VEC   = 4,
    parameter int CNT_W     = 3,
    parameter int IDX_W     = 4
) (
    input  logic [15:0]                dest,
    input  logic [7:0]                 vec,
    input  logic [NUM_PEERS*CNT_W-1:0] counts_flat,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx
);
    logic [CNT_W-1:0] sel_cnt;
    logic             dest_ok;
    logic             vec_ok;

    always_comb begin
        sel_cnt = '0;
        for (int p = 0; p < NUM_PEERS; p++) begin
            if (dest == 16'(p)) begin
                sel_cnt = counts_flat[p*CNT_W +: CNT_W];
            end
        end
    end

    assign dest_ok = {16'b0, dest} < 32'(NUM_PEERS);
    assign vec_ok  = {24'b0, vec} < 32'(sel_cnt);
    assign hit     = dest_ok && vec_ok;
    assign idx     = IDX_W'({16'b0, dest} * 32'(MAX_VEC) + {24'b0, vec});
endmodule

// File: rtl/mbox_irq_regs.sv
module mbox_irq_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mask_we,
    input  logic        stat_we,
    input  logic        stat_rdclr,
    input  logic        evt,
    input  logic [31:0] wdata,
    output logic [31:0] mask_q,
    output logic [31:0] stat_q,
    output logic        irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

    // event has priority over write and read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (evt) begin
            stat_q <= 32'd1;
        end else if (stat_we) begin
            stat_q <= wdata;
        end else if (stat_rdclr) begin
            stat_q <= '0;
        end
    end

    assign irq = |(stat_q & mask_q);

    // R10 / R11: an accepted event leaves the status at one
    assert_event_sets_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (stat_q == 32'd1));

    // R3: an undisturbed read-clear empties the status
    assert_rdclr_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdclr && !evt && !stat_we) |=> (stat_q == 32'd0));
endmodule

// File: rtl/mbox_bell_regs.sv
module mbox_bell_regs
    import mbox_pkg::*;
#(
    parameter int NUM_PEERS = 4,
    parameter int MAX_VEC   = 4,
    localparam int PEER_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
    localparam int CNT_W    = $clog2(MAX_VEC + 1),
    localparam int NUM_NOTE = NUM_PEERS * MAX_VEC,
    localparam int IDX_W    = (NUM_NOTE > 1) ? $clog2(NUM_NOTE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ready,
    output logic                bus_rvalid,
    output logic [31:0]         bus_rdata,
    input  logic [15:0]         local_id,
    input  logic                msi_mode,
    input  logic                local_event,
    input  logic                cfg_we,
    input  logic [PEER_W-1:0]   cfg_peer,
    input  logic [CNT_W-1:0]    cfg_count,
    output logic [NUM_NOTE-1:0] notify,
    output logic                irq
);
    mbox_state_e state_q, state_d;

    logic                       accept;
    logic [7:0]                 wr_addr;
    logic                       mask_we, stat_we, stat_rdclr, evt;
    logic                       bell_wr, bell_hit;
    logic [IDX_W-1:0]           bell_idx, ring_idx_q;
    logic [31:0]                mask_q, stat_q, rd_mux, rdata_q;
    logic [NUM_PEERS*CNT_W-1:0] counts_flat;

    assign accept     = bus_sel && (state_q == ST_IDLE);
    assign wr_addr    = bus_addr & 8'hFC;
    assign mask_we    = accept && bus_wr && (wr_addr == OFS_MASK);
    assign stat_we    = accept && bus_wr && (wr_addr == OFS_STAT);
    assign bell_wr    = accept && bus_wr && (wr_addr == OFS_BELL);
    assign stat_rdclr = accept && !bus_wr && (bus_addr == OFS_STAT);
    assign evt        = local_event && !msi_mode;

    mbox_vec_table #(
        .NUM_PEERS(NUM_PEERS), .MAX_VEC(MAX_VEC), .PEER_W(PEER_W), .CNT_W(CNT_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_peer(cfg_peer),
        .cfg_count(cfg_count), .counts_flat(counts_flat)
    );

    mbox_bell_check #(
        .NUM_PEERS(NUM_PEERS), .MAX_VEC(MAX_VEC), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) i_check (
        .dest(bus_wdata[31:16]), .vec(bus_wdata[7:0]), .counts_flat(counts_flat),
        .hit(bell_hit), .idx(bell_idx)
    );

    mbox_irq_regs i_irq (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .stat_we(stat_we),
        .stat_rdclr(stat_rdclr), .evt(evt), .wdata(bus_wdata),
        .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
    );

    // reads decode the full offset
    always_comb begin
        case (bus_addr)
            OFS_MASK: rd_mux = mask_q;
            OFS_STAT: rd_mux = stat_q;
            OFS_POS:  rd_mux = {16'b0, local_id};
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !bus_wr)             state_d = ST_RDATA;
                else if (bell_wr && bell_hit)      state_d = ST_RING;
            end
            ST_RDATA: state_d = ST_IDLE;
            ST_RING:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rdata_q    <= '0;
            ring_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && !bus_wr)    rdata_q    <= rd_mux;
            if (bell_wr && bell_hit)  ring_idx_q <= bell_idx;
        end
    end

    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        notify     = '0;
        unique case (state_q)
            ST_IDLE:  bus_ready = 1'b1;
            ST_RDATA: bus_rvalid = 1'b1;
            ST_RING:  notify[ring_idx_q] = 1'b1;
            default:  bus_ready = 1'b0;
        endcase
    end

    assign bus_rdata = rdata_q;

    // R7: at most one notify bit at a time, and never two cycles running
    assert_notify_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(notify));
    assert_notify_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (notify != '0) |=> (notify == '0));

    // R8: unknown destination produces no pulse
    assert_bad_peer_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_wr && ({16'b0, bus_wdata[31:16]} >= 32'(NUM_PEERS))) |=> (notify == '0));

    // R13: read response stalls the bus for one cycle
    assert_read_resp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bus_wr) |=> (bus_rvalid && !bus_ready));
endmodule

// File: tb/test_mbox_bell_regs.sv
`timescale 1ns/1ps
module test_mbox_bell_regs;
    localparam int NP = 4;
    localparam int MV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, irq;
    logic [31:0] bus_rdata;
    logic [15:0] local_id = 16'h0003;
    logic        msi_mode = 1'b0, local_event = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_peer = '0;
    logic [2:0]  cfg_count = '0;
    logic [NP*MV-1:0] notify;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] got_rdata;
    logic        got_rvalid, got_ready, got_ready_after;
    logic [NP*MV-1:0] got_notify, got_notify_after;

    always #2.5 clk = ~clk;

    mbox_bell_regs #(.NUM_PEERS(NP), .MAX_VEC(MV)) i_mbox_bell_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .local_id(local_id),
        .msi_mode(msi_mode), .local_event(local_event), .cfg_we(cfg_we),
        .cfg_peer(cfg_peer), .cfg_count(cfg_count), .notify(notify), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic w, input logic [7:0] a, input logic [31:0] d, input logic ev);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d; local_event = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; local_event = 1'b0;
        got_rdata = bus_rdata; got_rvalid = bus_rvalid;
        got_ready = bus_ready; got_notify = notify;
        @(negedge clk);
        got_notify_after = notify; got_ready_after = bus_ready;
    endtask

    task automatic cfg(input logic [1:0] p, input logic [2:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_peer = p; cfg_count = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ring(input string tag, input logic [15:0] dst, input logic [15:0] low,
                        input int exp_bit);
        logic [31:0] exp;
        xact(1'b1, 8'h0C, {dst, low}, 1'b0);
        exp = (exp_bit < 0) ? 32'd0 : (32'd1 << exp_bit);
        chk(tag, 32'(got_notify), exp);
        chk({tag, " pulse ends"}, 32'(got_notify_after), 32'd0);
    endtask

    // {write, addr, data, expected read}
    localparam logic [72:0] VEC_TBL [15] = '{
        {1'b1, 8'h00, 32'h0000_00F0, 32'h0},          // R2 mask write
        {1'b0, 8'h00, 32'h0,         32'h0000_00F0},  // R2 readback
        {1'b1, 8'h01, 32'h0000_000F, 32'h0},          // R2 low bits ignored
        {1'b0, 8'h00, 32'h0,         32'h0000_000F},  // R2
        {1'b1, 8'h04, 32'h0000_00A5, 32'h0},          // R4 status write
        {1'b0, 8'h04, 32'h0,         32'h0000_00A5},  // R3 read returns
        {1'b0, 8'h04, 32'h0,         32'h0},          // R3 cleared
        {1'b0, 8'h08, 32'h0,         32'h0000_0003},  // R5 position
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},          // R5 write ignored
        {1'b0, 8'h08, 32'h0,         32'h0000_0003},  // R5
        {1'b0, 8'h10, 32'h0,         32'h0},          // R6 undefined read
        {1'b1, 8'h20, 32'h0000_1234, 32'h0},          // R6 undefined write
        {1'b0, 8'h00, 32'h0,         32'h0000_000F},  // R6 mask untouched
        {1'b0, 8'h02, 32'h0,         32'h0},          // R6 unaligned read
        {1'b0, 8'hFC, 32'h0,         32'h0}           // R6 top of window
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 notify", 32'(notify), 32'd0);
        chk("R1 ready", 32'(bus_ready), 32'd1);
        chk("R1 rvalid", 32'(bus_rvalid), 32'd0);
        xact(1'b0, 8'h00, 32'h0, 1'b0);
        chk("R1 mask zero", got_rdata, 32'd0);
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R1 status zero", got_rdata, 32'd0);
        ring("R1 counts zero drop", 16'd0, 16'h0000, -1);

        for (int i = 0; i < 15; i++) begin
            xact(VEC_TBL[i][72], VEC_TBL[i][71:64], VEC_TBL[i][63:32], 1'b0);
            if (!VEC_TBL[i][72]) begin
                chk($sformatf("R2-6 table %0d rdata", i), got_rdata, VEC_TBL[i][31:0]);
                chk($sformatf("R13 table %0d rvalid", i), 32'(got_rvalid), 32'd1);
                chk($sformatf("R13 table %0d ready low", i), 32'(got_ready), 32'd0);
            end
        end

        // R6: undefined write left status alone too
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R6 status untouched", got_rdata, 32'd0);

        // R9 table: peer0=2, peer1=4, peer2=0, peer3=7 clamps to 4
        cfg(2'd0, 3'd2);
        cfg(2'd1, 3'd4);
        cfg(2'd2, 3'd0);
        cfg(2'd3, 3'd7);
        ring("R7 peer1 vec3", 16'd1, 16'h0003, 7);
        ring("R7 peer0 vec1", 16'd0, 16'h0001, 1);
        ring("R7 mid bits ignored", 16'd0, 16'hFF01, 1);
        ring("R9 peer0 vec2 drop", 16'd0, 16'h0002, -1);
        ring("R9 peer2 empty drop", 16'd2, 16'h0000, -1);
        ring("R9 peer3 clamp vec3", 16'd3, 16'h0003, 15);
        ring("R9 peer3 vec4 drop", 16'd3, 16'h0004, -1);
        ring("R8 peer4 drop", 16'd4, 16'h0000, -1);
        ring("R8 peer 0x8000 drop", 16'h8000, 16'h0000, -1);
        xact(1'b1, 8'h0C, {16'd1, 16'h0000}, 1'b0);
        chk("R13 ready low while ringing", 32'(got_ready), 32'd0);

        // R10 local event
        @(negedge clk); local_event = 1'b1;
        @(negedge clk); local_event = 1'b0;
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R10 event sets status", got_rdata, 32'd1);
        msi_mode = 1'b1;
        @(negedge clk); local_event = 1'b1;
        @(negedge clk); local_event = 1'b0;
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R10 msi mode ignores event", got_rdata, 32'd0);
        msi_mode = 1'b0;

        // R11 coincidence
        xact(1'b1, 8'h04, 32'h0000_0040, 1'b0);
        xact(1'b0, 8'h04, 32'h0, 1'b1);
        chk("R11 read sees old value", got_rdata, 32'h40);
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R11 event beats read-clear", got_rdata, 32'd1);
        xact(1'b1, 8'h04, 32'h0000_0030, 1'b1);
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R11 event beats write", got_rdata, 32'd1);

        // R12 irq
        xact(1'b1, 8'h00, 32'h2, 1'b0);
        xact(1'b1, 8'h04, 32'h2, 1'b0);
        chk("R12 irq enabled bit", 32'(irq), 32'd1);
        xact(1'b1, 8'h00, 32'h1, 1'b0);
        chk("R12 irq masked", 32'(irq), 32'd0);
        xact(1'b1, 8'h04, 32'h3, 1'b0);
        chk("R12 irq again", 32'(irq), 32'd1);
        xact(1'b0, 8'h04, 32'h0, 1'b0);
        chk("R12 irq after clear", 32'(irq), 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule